// File: doc/BRIEF.md
# Supply Rail Sequencer

This block brings a chain of supply rails up one stage at a time and takes them down again in the opposite order. A rail stage is enabled only after the stage below it has reported power-good, where power-good means that rail has passed its under-voltage fault threshold. Power-up is requested by the power switch together with a comparator saying the input supply is above 10 V. Power-down is requested by the switch going off or by a second comparator saying the input has dropped below 9 V. Between the two thresholds the sequencer holds its present state, which gives the input check its hysteresis. Power-down is purely time-based: rails are dropped at fixed intervals, with no wait on any feedback.

A stage that fails to reach power-good within a programmable window, 15 ms by default at a 1 MHz clock, aborts the ramp. The rails already enabled are shut down in reverse order, and a faulted-off flag is latched. An active-low alert gathers the per-channel fault and warning comparator flags together with this timeout. The alert stays latched until a clear-faults strobe arrives while no fault condition is present. A latched faulted-off state blocks any new power-up until it is cleared, and it can only be cleared once every rail is off.

The eight default stages, lowest first, are:
- core 1.0 V
- 1.8 V
- 2.0 V
- transceiver analog 1.0 V
- transceiver termination 1.2 V
- 3.3 V
- the 1.5 V memory rail, with both 0.75 V termination rails on the same enable
- transceiver auxiliary 1.8 V

Top module: `rail_seq_ctrl`

## Requirements
- R1: During and right after reset every bit of `rail_en` is 0, `alert_n` is 1 and `faulted_off` is 0.
- R2: From the all-off idle state, the clock edge that samples `sw_on`=1, `vin_hi`=1 and `faulted_off`=0 sets `rail_en[0]`, and no other bit. No rail is enabled while `vin_hi` is 0.
- R3: Rails come up in index order. Bit 0 is the core 1.0 V stage and bit 7 the auxiliary 1.8 V stage. Bit 6 is the single enable shared by the 1.5 V rail and both 0.75 V termination rails. `rail_en[k+1]` is set at the edge that samples `pgood[k]`=1 while `rail_en[k]` is the highest enabled bit. At any time, `rail_en[i]`=1 implies `rail_en[j]`=1 for every j<i. At most one bit changes per cycle.
- R4: An off request is `sw_on`=0 or `vin_lo`=1. During ramp-up or when fully up, the edge that samples an off request clears the highest enabled bit. After that, one further bit, the next lower, is cleared every OFF_DLY_CYC cycles until all bits are 0.
- R5: With `sw_on`=1 and both `vin_hi` and `vin_lo` at 0, the sequencer neither starts from idle nor begins shutting down when fully up.
- R6: If the highest enabled stage k has `pgood[k]` sampled at 0 on TMO_CYC consecutive edges after its enable rose, the last of those edges clears `rail_en[k]`, sets `faulted_off` and drives `alert_n` low. The lower rails then drop as in R4.
- R7: While `faulted_off` is 1, a power-up request is ignored and `rail_en` stays 0.
- R8: Any set bit of `flt_cond` drives `alert_n` low at the next edge. It stays low until an edge that samples `clr_flt`=1 with `flt_cond` all 0 and with either `faulted_off`=0 or all rails off.
- R9: `faulted_off` is cleared only by an edge that samples `clr_flt`=1 after the off sequence has completed. A clear while rails are still on leaves it at 1.
- R10: Once an off sequence has begun it runs to completion, even if a power-up request reappears. The power-up is honoured two edges after the last rail drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_on | input | 1 | Power switch in the ON position |
| vin_hi | input | 1 | Input supply comparator: above 10 V |
| vin_lo | input | 1 | Input supply comparator: below 9 V |
| pgood | input | N_STAGE | Per-stage rail above its under-voltage fault limit |
| flt_cond | input | N_STAGE | Per-channel fault or warning condition present |
| clr_flt | input | 1 | Clear-faults strobe |
| rail_en | output | N_STAGE | Per-stage rail enable |
| alert_n | output | 1 | Latched alert, active low |
| faulted_off | output | 1 | Latched faulted-off indicator |

## Verification
The hardest case to reach is a timeout in the middle of the ramp, followed by a clear-faults strobe that lands while the abort shutdown is still dropping rails. The bench models each rail as a plant whose power-good follows its enable after a per-rail delay. It can pin one stage's power-good low, which lets the ramp stall at stage 4 for exactly the timeout window. The bench then fires the clear during the spaced shutdown, checks that both latches hold, and fires the clear again once everything is off. Off requests arriving mid-ramp are produced by releasing the switch as soon as the plant has brought three rails up.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RAMP = 2'd1,
      SQ_UP   = 2'd2,
      SQ_DOWN = 2'd3
   } seq_st_e;
endpackage

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic hit
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_q + CW'(1);
   end

   assign hit = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/rail_seq_decode.sv
module rail_seq_decode #(
   parameter int N_STAGE = 8,
   parameter int LVL_W   = 4
) (
   input  logic [LVL_W-1:0]   lvl,
   output logic [N_STAGE-1:0] en,
   output logic [N_STAGE-1:0] top
);
   for (genvar i = 0; i < N_STAGE; i++) begin : g_stage
      assign en[i]  = (lvl > LVL_W'(i));
      assign top[i] = (lvl == LVL_W'(i + 1));
   end
endmodule

// File: rtl/rail_seq_flags.sv
module rail_seq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic cond_any,
   input  logic tmo_evt,
   input  logic clr_flt,
   input  logic seq_idle,
   output logic alert_n,
   output logic faulted_off
);
   logic alert_q, fo_q;
   logic alert_clr_ok;

   assign alert_clr_ok = clr_flt && !cond_any && !(fo_q && !seq_idle);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alert_q <= 1'b0;
         fo_q    <= 1'b0;
      end else begin
         if (cond_any || tmo_evt) alert_q <= 1'b1;
         else if (alert_clr_ok)   alert_q <= 1'b0;
         if (tmo_evt)                    fo_q <= 1'b1;
         else if (clr_flt && seq_idle)   fo_q <= 1'b0;
      end
   end

   assign alert_n     = !alert_q;
   assign faulted_off = fo_q;
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
   import rail_seq_pkg::*;
#(
   parameter int N_STAGE     = 8,
   parameter int TMO_CYC     = 15000,
   parameter int OFF_DLY_CYC = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_on,
   input  logic               vin_hi,
   input  logic               vin_lo,
   input  logic [N_STAGE-1:0] pgood,
   input  logic [N_STAGE-1:0] flt_cond,
   input  logic               clr_flt,
   output logic [N_STAGE-1:0] rail_en,
   output logic               alert_n,
   output logic               faulted_off
);
   localparam int LVL_W = $clog2(N_STAGE + 1);

   if (N_STAGE < 2) begin : g_bad_stages
      $error("rail_seq_ctrl: N_STAGE must be at least 2");
   end
   if (TMO_CYC < 1 || OFF_DLY_CYC < 1) begin : g_bad_timers
      $error("rail_seq_ctrl: timer limits must be at least 1");
   end

   seq_st_e          st_q, st_d;
   logic [LVL_W-1:0] lvl_q, lvl_d;
   logic [N_STAGE-1:0] top_oh;
   logic tmo_clr, tmo_hit, dly_clr, dly_hit, tmo_evt;
   logic off_req, start_ok, cur_good;

   assign off_req  = !sw_on || vin_lo;
   assign start_ok = sw_on && vin_hi && !faulted_off;
   assign cur_good = |(pgood & top_oh);

   rail_seq_decode #(.N_STAGE(N_STAGE), .LVL_W(LVL_W)) dec_i (
      .lvl(lvl_q), .en(rail_en), .top(top_oh));

   rail_seq_timer #(.LIMIT(TMO_CYC)) tmo_i (
      .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .hit(tmo_hit));

   rail_seq_timer #(.LIMIT(OFF_DLY_CYC)) dly_i (
      .clk(clk), .rst_n(rst_n), .clr(dly_clr), .hit(dly_hit));

   rail_seq_flags flg_i (
      .clk(clk), .rst_n(rst_n), .cond_any(|flt_cond), .tmo_evt(tmo_evt),
      .clr_flt(clr_flt), .seq_idle(st_q == SQ_IDLE),
      .alert_n(alert_n), .faulted_off(faulted_off));

   always_comb begin
      st_d    = st_q;
      lvl_d   = lvl_q;
      tmo_clr = 1'b1;
      dly_clr = 1'b1;
      tmo_evt = 1'b0;
      unique case (st_q)
         SQ_IDLE: begin
            if (start_ok) begin
               st_d  = SQ_RAMP;
               lvl_d = LVL_W'(1);
            end
         end
         SQ_RAMP: begin
            if (off_req) begin
               st_d  = SQ_DOWN;
               lvl_d = lvl_q - LVL_W'(1);
            end else if (cur_good) begin
               if (lvl_q == LVL_W'(N_STAGE)) st_d = SQ_UP;
               else                          lvl_d = lvl_q + LVL_W'(1);
            end else if (tmo_hit) begin
               tmo_evt = 1'b1;
               st_d    = SQ_DOWN;
               lvl_d   = lvl_q - LVL_W'(1);
            end else begin
               tmo_clr = 1'b0;
            end
         end
         SQ_UP: begin
            if (off_req) begin
               st_d  = SQ_DOWN;
               lvl_d = lvl_q - LVL_W'(1);
            end
         end
         SQ_DOWN: begin
            if (lvl_q == '0)  st_d = SQ_IDLE;
            else if (dly_hit) lvl_d = lvl_q - LVL_W'(1);
            else              dly_clr = 1'b0;
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         lvl_q <= '0;
      end else begin
         st_q  <= st_d;
         lvl_q <= lvl_d;
      end
   end
endmodule

// File: rtl/rail_seq_ctrl_chk.sv
module rail_seq_ctrl_chk #(
   parameter int N_STAGE = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sw_on,
   input logic               vin_hi,
   input logic               vin_lo,
   input logic [N_STAGE-1:0] pgood,
   input logic [N_STAGE-1:0] flt_cond,
   input logic               clr_flt,
   input logic [N_STAGE-1:0] rail_en,
   input logic               alert_n,
   input logic               faulted_off
);
   // R3
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rail_en ^ $past(rail_en)) <= 1);

   // R2
   first_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_en[0]) |-> $past(sw_on && vin_hi));

   for (genvar i = 1; i < N_STAGE; i++) begin : g_ord
      // R3
      cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rail_en[i] |-> rail_en[i-1]);
      // R3
      pg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rail_en[i]) |-> $past(pgood[i-1]));
   end

   // R4
   no_rise_on_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_on || vin_lo) |=> ((rail_en & ~$past(rail_en)) == '0));

   // R8
   alert_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_cond != '0) |=> !alert_n);

   // R8
   alert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alert_n && !clr_flt) |=> !alert_n);

   // R6
   fo_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      faulted_off |-> !alert_n);

   // R9
   fo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (faulted_off && !clr_flt) |=> faulted_off);
endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk #(.N_STAGE(N_STAGE)) chk_i (
   .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .vin_hi(vin_hi), .vin_lo(vin_lo),
   .pgood(pgood), .flt_cond(flt_cond), .clr_flt(clr_flt), .rail_en(rail_en),
   .alert_n(alert_n), .faulted_off(faulted_off));

// File: tb/rail_seq_ctrl_tb_top.sv
module rail_seq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 8;
   localparam int TMO  = 20;
   localparam int OFFD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_on = 1'b0, vin_hi = 1'b0, vin_lo = 1'b0, clr_flt = 1'b0;
   logic [N-1:0] pgood = '0, flt_cond = '0, stuck = '0;
   logic [N-1:0] rail_en;
   logic alert_n, faulted_off;

   int checks = 0, errors = 0, cyc_cnt = 0;
   bit done = 0;

   // reference model state
   int m_st = 0, m_lvl = 0, m_tmr = 0, m_dly = 0;
   bit m_al = 0, m_fo = 0;
   int pcnt [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   rail_seq_ctrl #(.N_STAGE(N), .TMO_CYC(TMO), .OFF_DLY_CYC(OFFD)) dut_i (
      .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .vin_hi(vin_hi), .vin_lo(vin_lo),
      .pgood(pgood), .flt_cond(flt_cond), .clr_flt(clr_flt),
      .rail_en(rail_en), .alert_n(alert_n), .faulted_off(faulted_off));

   // behavioural reference: 0 idle, 1 ramp, 2 up, 3 down
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_lvl = 0; m_tmr = 0; m_dly = 0; m_al = 0; m_fo = 0;
      end else begin
         bit offr, tevt, was_idle;
         offr = !sw_on || vin_lo;
         tevt = 0;
         was_idle = (m_st == 0);
         case (m_st)
            0: if (sw_on && vin_hi && !m_fo) begin m_st = 1; m_lvl = 1; m_tmr = 0; end
            1: if (offr) begin m_st = 3; m_lvl--; m_dly = 0; end
               else if (pgood[m_lvl-1]) begin
                  if (m_lvl == N) m_st = 2; else begin m_lvl++; m_tmr = 0; end
               end else if (m_tmr == TMO-1) begin tevt = 1; m_st = 3; m_lvl--; m_dly = 0; end
               else m_tmr++;
            2: if (offr) begin m_st = 3; m_lvl--; m_dly = 0; end
            default: if (m_lvl == 0) m_st = 0;
               else if (m_dly == OFFD-1) begin m_lvl--; m_dly = 0; end
               else m_dly++;
         endcase
         if (m_st == 1 && !tevt && m_lvl > 0 && m_tmr == 0) ; // fresh stage
         if (flt_cond != 0 || tevt) m_al = 1;
         else if (clr_flt && !(m_fo && !was_idle)) m_al = 0;
         if (tevt) m_fo = 1;
         else if (clr_flt && was_idle) m_fo = 0;
      end
   end

   function automatic logic [N-1:0] exp_en();
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = (m_lvl > i);
      return v;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc_cnt);
      end
   endtask

   // per-cycle comparison, rail plant and watchdog
   always @(negedge clk) begin
      cyc_cnt++;
      check("R3 rail_en vs model", 32'(rail_en), 32'(exp_en()));
      check("R8 alert_n vs model", 32'(alert_n), 32'(!m_al));
      check("R9 faulted_off vs model", 32'(faulted_off), 32'(m_fo));
      for (int i = 0; i < N; i++) begin
         if (!rail_en[i]) pcnt[i] = 0; else pcnt[i]++;
         pgood[i] = rail_en[i] && !stuck[i] && (pcnt[i] >= 1 + (i % 3));
      end
      if (cyc_cnt > 20000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired act=%0d exp<20000", cyc_cnt);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_en(logic [N-1:0] v, string tag);
      int k = 0;
      while (rail_en !== v && k < 400) begin @(negedge clk); k++; end
      check(tag, 32'(rail_en), 32'(v));
   endtask

   task automatic pulse_clr();
      clr_flt = 1; @(negedge clk); clr_flt = 0;
   endtask

   initial begin
      for (int i = 0; i < N; i++) pcnt[i] = 0;
      cyc(3);
      check("R1 rail_en in reset", 32'(rail_en), 0);
      check("R1 alert_n in reset", 32'(alert_n), 1);
      rst_n = 1;
      cyc(1);
      check("R1 rail_en after reset", 32'(rail_en), 0);
      check("R1 faulted_off after reset", 32'(faulted_off), 0);

      // switch on, input between thresholds: no start
      sw_on = 1;
      cyc(10);
      check("R5 no start between thresholds", 32'(rail_en), 0);
      check("R2 no start without vin_hi", 32'(rail_en), 0);
      vin_hi = 1;
      cyc(1);
      check("R2 first stage enabled", 32'(rail_en), 32'h01);
      wait_en('1, "R3 full ramp reached");

      // hysteresis band while up
      vin_hi = 0;
      cyc(20);
      check("R5 stays up between thresholds", 32'(rail_en), 32'hFF);

      // brown-out shutdown timing
      vin_lo = 1;
      cyc(1);
      check("R4 top rail dropped first", 32'(rail_en), 32'h7F);
      cyc(OFFD-1);
      check("R4 hold during off delay", 32'(rail_en), 32'h7F);
      cyc(1);
      check("R4 next rail dropped", 32'(rail_en), 32'h3F);
      wait_en('0, "R4 all rails off");
      vin_lo = 0; vin_hi = 1;

      // off request mid-ramp, then restart request during shutdown
      wait_en(8'h07, "R3 partial ramp");
      sw_on = 0;
      cyc(1);
      check("R4 mid-ramp drops highest", 32'(rail_en), 32'h03);
      sw_on = 1;
      cyc(1);
      check("R10 no restart during shutdown", 32'(rail_en), 32'h03);
      wait_en('0, "R10 shutdown completes");
      cyc(2);
      check("R10 restart after shutdown", 32'(rail_en), 32'h01);
      wait_en('1, "R3 full ramp again");

      // timeout on stage 4
      sw_on = 0;
      wait_en('0, "R4 off before timeout test");
      stuck[4] = 1;
      sw_on = 1;
      wait_en(8'h1F, "R6 stalled at stage 4");
      cyc(TMO-1);
      check("R6 still waiting", 32'(rail_en), 32'h1F);
      check("R6 no fault yet", 32'(faulted_off), 0);
      cyc(1);
      check("R6 stalled rail dropped", 32'(rail_en), 32'h0F);
      check("R6 faulted_off set", 32'(faulted_off), 1);
      check("R6 alert set", 32'(alert_n), 0);
      pulse_clr();
      check("R9 clear ignored while rails on", 32'(faulted_off), 1);
      check("R8 alert held while rails on", 32'(alert_n), 0);
      wait_en('0, "R6 abort shutdown completes");
      cyc(4);
      check("R7 restart blocked while faulted", 32'(rail_en), 0);
      pulse_clr();
      check("R9 faulted_off cleared in idle", 32'(faulted_off), 0);
      check("R8 alert cleared in idle", 32'(alert_n), 1);
      stuck[4] = 0;
      wait_en('1, "R7 restart after clear");

      // condition-driven alert
      flt_cond = 8'h10;
      cyc(1);
      check("R8 alert on condition", 32'(alert_n), 0);
      flt_cond = 8'h02;
      pulse_clr();
      check("R8 clear refused while condition present", 32'(alert_n), 0);
      flt_cond = '0;
      cyc(5);
      check("R8 alert sticky", 32'(alert_n), 0);
      pulse_clr();
      check("R8 alert cleared", 32'(alert_n), 1);
      check("R8 rails unaffected by alert", 32'(rail_en), 32'hFF);

      cyc(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule